// File: doc/BRIEF.md
# GPIO Port with Atomic Set/Clear Aliases

This block is a general-purpose I/O port of `NPINS` pins (16 by default) reached through a simple synchronous register port. The port has an address, a write strobe with write data, and a read strobe with registered read data. Three per-pin state registers control the pins:

- output value;
- driver enable (direction);
- input-buffer enable.

Each register can be reached three ways: a full-write word, a set-only word and a clear-only word. The set and clear words let independent software threads change single pins without a read-modify-write.

The block drives a value and an output enable per pin toward external tristate pads. It takes the pad levels back in through a two-flop synchroniser. For each bit, a data read returns one of two values, chosen by that bit's input-buffer enable:

- enable at 1: the synchronised pin level;
- enable at 0: the internal output flip-flop.

The output flip-flop remains writable in either case. Open-drain behaviour follows from this. Software holds the data bit at 0 with the input buffer on, then toggles the driver enable to pull the pin low or release it.

Top module: `gpio_port`

## Requirements
- R1: After reset the output-value, driver-enable and input-enable registers are all zero, so `pad_oe` and `pad_out` are 0 and every mapped read returns 0 while the pads are low.
- R2: Data words use byte offset 0x00 (full write), 0x04 (set bits written as 1) and 0x08 (clear bits written as 1); `pad_out` shows the new flip-flop value in the cycle after the write edge.
- R3: A write to offset 0x0C replaces every driver-enable bit; `pad_oe` equals the driver-enable register, a 1 enabling the driver and a 0 three-stating the pin.
- R4: Offset 0x10 sets only the driver-enable bits written as 1 and offset 0x14 clears only the bits written as 1; bits written as 0 keep their value.
- R5: The input-enable register uses offset 0x18 (full), 0x1C (set) and 0x20 (clear) with the same bit rules as R4, and a read of any of the three returns the register.
- R6: Reads of 0x10 and 0x14 return the driver-enable register; reads of 0x04 and 0x08 return the same value as a read of 0x00.
- R7: A data read returns, for each bit with input enable 1, the pin level seen through a two-flop synchroniser, and for each bit with input enable 0, the output flip-flop.
- R8: Data writes update the output flip-flop even for bits whose input enable is 1; the new value appears on `pad_out` but not in data reads of those bits.
- R9: With a data bit at 0 and its input enable at 1, setting its driver enable drives the pin low and clearing it releases the pin; data reads then report the real pin level.
- R10: Accesses to any offset other than the nine listed (including offsets that are not multiples of 4) read as zero and leave all registers unchanged.
- R11: `rd_data` is loaded at the clock edge that samples `rd_en` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW (6) | Byte offset of the accessed register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | NPINS (16) | Write data, one bit per pin |
| rd_en | input | 1 | Read strobe |
| rd_data | output | NPINS (16) | Registered read data |
| pad_in | input | NPINS (16) | Pin levels returned from the pads |
| pad_out | output | NPINS (16) | Value driven toward each pad |
| pad_oe | output | NPINS (16) | Driver enable per pad, 1 drives |

## Verification
Register writes take effect at the write edge, so the bench samples `pad_out` and `pad_oe` on the falling edge right after the write edge. Read data is due on the falling edge after the edge that samples `rd_en`. Pin levels need two more edges to cross the synchroniser. For that reason the bench leaves at least three idle cycles between any change of pin level and the data read that should see it. Each random step follows the same schedule: a write, a change of the external pin level, three idle cycles, then a read of a random offset. After the read, one more idle cycle confirms that `rd_data` holds.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Register banks, in the order their offsets appear in the map
  typedef enum logic [1:0] {
    BANK_DATA = 2'd0,
    BANK_DIR  = 2'd1,
    BANK_INEN = 2'd2
  } bank_e;

  localparam int unsigned NUM_BANKS   = 3;
  localparam int unsigned NUM_ALIASES = 3;  // full, set, clear
  localparam int unsigned NUM_WORDS   = NUM_BANKS * NUM_ALIASES;
endpackage

// File: rtl/gpio_bitreg.sv
module gpio_bitreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_full,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (wr_full) q <= wdata;
    else if (wr_set)  q <= q | wdata;
    else if (wr_clr)  q <= q & ~wdata;
  end

  // R4
  set_only_ones_chk: assert property (@(posedge clk) disable iff (rst)
    wr_set && !wr_full |=> q == ($past(q) | $past(wdata)));
  // R4
  clr_only_ones_chk: assert property (@(posedge clk) disable iff (rst)
    wr_clr && !wr_full && !wr_set |=> q == ($past(q) & ~$past(wdata)));
  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_full && !wr_set && !wr_clr |=> $stable(q));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) stage_q[s] <= rst ? '0 : d;
    end else begin : g_next
      always_ff @(posedge clk) stage_q[s] <= rst ? '0 : stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned AW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [NPINS-1:0] wr_data,
  input  logic             rd_en,
  output logic [NPINS-1:0] rd_data,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  localparam int unsigned WIW = AW - 2;

  logic [WIW-1:0]   word_idx;
  logic             mapped;
  logic [NPINS-1:0] bank_q [NUM_BANKS];
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] data_view;
  logic [NPINS-1:0] rd_next;

  assign word_idx = addr[AW-1:2];
  assign mapped   = (addr[1:0] == 2'b00) && (int'(word_idx) < NUM_WORDS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned BASE = b * NUM_ALIASES;
    logic hit_full, hit_set, hit_clr;
    assign hit_full = wr_en && mapped && (int'(word_idx) == BASE);
    assign hit_set  = wr_en && mapped && (int'(word_idx) == BASE + 1);
    assign hit_clr  = wr_en && mapped && (int'(word_idx) == BASE + 2);
    gpio_bitreg #(.W(NPINS)) u_reg (
      .clk(clk), .rst(rst),
      .wr_full(hit_full), .wr_set(hit_set), .wr_clr(hit_clr),
      .wdata(wr_data), .q(bank_q[b])
    );
  end

  gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  assign data_view = (bank_q[BANK_INEN] & pin_sync) | (~bank_q[BANK_INEN] & bank_q[BANK_DATA]);

  always_comb begin
    rd_next = '0;
    if (mapped) begin
      unique case (int'(word_idx) / NUM_ALIASES)
        0:       rd_next = data_view;
        1:       rd_next = bank_q[BANK_DIR];
        default: rd_next = bank_q[BANK_INEN];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  assign pad_out = bank_q[BANK_DATA];
  assign pad_oe  = bank_q[BANK_DIR];

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && !mapped |=> $stable({pad_out, pad_oe, bank_q[BANK_INEN]}));
  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && !mapped |=> rd_data == '0);
  // R6
  dir_alias_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && (addr == AW'(6'h10) || addr == AW'(6'h14)) |=> rd_data == $past(pad_oe));
  // R11
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  localparam int NP = 16;
  localparam int AW = 6;

  logic          clk = 0;
  logic          rst = 1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 0, rd_en = 0;
  logic [NP-1:0] wr_data = '0;
  logic [NP-1:0] rd_data, pad_out, pad_oe, pad_in, ext;

  always #4 clk = ~clk;  // 125 MHz

  // External world: undriven pins follow ext (pull level)
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_port #(.NPINS(NP), .AW(AW)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int n_cmp = 0, n_bad = 0;
  logic [NP-1:0] m_data = '0, m_dir = '0, m_inen = '0;

  task automatic chk(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] pin_lvl();
    return (m_dir & m_data) | (~m_dir & ext);
  endfunction

  function automatic logic [NP-1:0] exp_read(logic [AW-1:0] a);
    if (a[1:0] != 0) return '0;
    case (a)
      6'h00, 6'h04, 6'h08: return (m_inen & pin_lvl()) | (~m_inen & m_data);
      6'h0C, 6'h10, 6'h14: return m_dir;
      6'h18, 6'h1C, 6'h20: return m_inen;
      default:             return '0;
    endcase
  endfunction

  function automatic void model_wr(logic [AW-1:0] a, logic [NP-1:0] d);
    case (a)
      6'h00: m_data = d;
      6'h04: m_data = m_data | d;
      6'h08: m_data = m_data & ~d;
      6'h0C: m_dir = d;
      6'h10: m_dir = m_dir | d;
      6'h14: m_dir = m_dir & ~d;
      6'h18: m_inen = d;
      6'h1C: m_inen = m_inen | d;
      6'h20: m_inen = m_inen & ~d;
      default: ;
    endcase
  endfunction

  task automatic bus_wr(logic [AW-1:0] a, logic [NP-1:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    model_wr(a, d);
  endtask

  task automatic bus_rd(logic [AW-1:0] a, output logic [NP-1:0] v);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
    v = rd_data;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(string tag, logic [AW-1:0] a);
    logic [NP-1:0] v;
    logic [NP-1:0] e;
    e = exp_read(a);
    bus_rd(a, v);
    chk(tag, v, e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [NP-1:0] v;
    void'($urandom(32'h5EED1234));
    ext = '0;
    idle(3); rst = 0; idle(1);

    // R1 reset state
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_out", pad_out, '0);
    rd_chk("R1 data read", 6'h00);
    rd_chk("R1 dir read", 6'h0C);
    rd_chk("R1 inen read", 6'h18);

    // R2 data aliases
    bus_wr(6'h00, 16'hA5A5); chk("R2 full", pad_out, 16'hA5A5);
    bus_wr(6'h04, 16'h000F); chk("R2 set", pad_out, 16'hA5AF);
    bus_wr(6'h08, 16'hA000); chk("R2 clr", pad_out, 16'h05AF);

    // R3 direction full write
    bus_wr(6'h0C, 16'h00FF); chk("R3 dir full", pad_oe, 16'h00FF);
    // R4 direction aliases
    bus_wr(6'h10, 16'h0F00); chk("R4 dir set", pad_oe, 16'h0FFF);
    bus_wr(6'h14, 16'h000F); chk("R4 dir clr", pad_oe, 16'h0FF0);
    // R6 alias reads
    rd_chk("R6 dir set read", 6'h10);
    rd_chk("R6 dir clr read", 6'h14);
    rd_chk("R6 data set read", 6'h04);
    rd_chk("R6 data clr read", 6'h08);

    // R5 input-enable aliases
    bus_wr(6'h18, 16'h00F0); rd_chk("R5 inen full", 6'h18);
    bus_wr(6'h1C, 16'h0003); rd_chk("R5 inen set", 6'h1C);
    bus_wr(6'h20, 16'h0010); rd_chk("R5 inen clr", 6'h20);
    chk("R5 model", m_inen, 16'h00E3);

    // R7 / R8: input buffers on, flip-flop still written
    bus_wr(6'h0C, 16'h0000);
    bus_wr(6'h18, 16'hFFFF);
    ext = 16'h3C3C;
    bus_wr(6'h00, 16'h1234);
    chk("R8 pad_out", pad_out, 16'h1234);
    idle(3);
    rd_chk("R7 pin level read", 6'h00);
    chk("R8 hidden", exp_read(6'h00), 16'h3C3C);
    bus_wr(6'h18, 16'h0000); rd_chk("R7 ff read", 6'h00);

    // R9 open-drain on bit 0 with pull-up
    ext = 16'h0001;
    bus_wr(6'h08, 16'h0001);
    bus_wr(6'h1C, 16'h0001);
    bus_wr(6'h10, 16'h0001);
    chk("R9 driving low", pad_oe[0] ? {15'b0, pad_out[0]} : 16'hFFFF, 16'h0000);
    idle(3); bus_rd(6'h00, v); chk("R9 read low", {15'b0, v[0]}, 16'h0000);
    bus_wr(6'h14, 16'h0001);
    chk("R9 released", {15'b0, pad_oe[0]}, 16'h0000);
    idle(3); bus_rd(6'h00, v); chk("R9 read high", {15'b0, v[0]}, 16'h0001);

    // R10 unmapped offsets
    bus_wr(6'h24, 16'hFFFF); bus_wr(6'h02, 16'hFFFF); bus_wr(6'h3C, 16'hFFFF);
    chk("R10 data kept", pad_out, m_data);
    chk("R10 dir kept", pad_oe, m_dir);
    rd_chk("R10 inen kept", 6'h18);
    rd_chk("R10 read 0x24", 6'h24);
    rd_chk("R10 read 0x01", 6'h01);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] wa, ra;
      logic [NP-1:0] hold;
      wa = ($urandom % 8 == 0) ? AW'($urandom) : AW'(($urandom % 9) * 4);
      ra = ($urandom % 8 == 0) ? AW'($urandom) : AW'(($urandom % 9) * 4);
      bus_wr(wa, NP'($urandom));
      chk("R2/R3 rand pad_out", pad_out, m_data);
      chk("R3 rand pad_oe", pad_oe, m_dir);
      ext = NP'($urandom);
      idle(3);
      rd_chk("R7 rand read", ra);
      hold = rd_data;
      idle(1);
      chk("R11 hold", rd_data, hold);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule